// File: doc/BRIEF.md
# Serial Flash Status Register Unit

This block holds the three status registers of a serial NOR flash slave and serves the commands that touch them. It watches a mode-0, single-bit SPI link (clock idles low, data sampled on the rising edge and changed on the falling edge) from inside a faster system clock domain. It captures the opcode, shifts status bytes out on MISO and updates the registers when chip select is released. The rest of the device reads the three registers from dedicated outputs. The busy flag is supplied by the array controller through an input.

A status write carries up to three data bytes in one frame. Only the configuration bits of each register take the new values. The write-enable latch and the reserved bits keep their state, and bit 0 always follows the busy input. A write is accepted only when enabled beforehand, either by the normal write-enable command or by the separate volatile-write enable. The volatile enable leaves the visible write-enable latch untouched.

Top module: `sfsr_unit`

## Requirements
- R1: Opcode 0x05 shifts out status register 1, 0x35 register 2 and 0x33 register 3, MSB first. The first bit is valid before the 9th rising SCK edge. Further bytes in the same frame repeat the selected register.
- R2: Opcode 0x06 sets the write-enable latch (register 1 bit 1) when chip select rises. Opcode 0x04 clears it and also cancels a pending volatile enable.
- R3: An accepted 0x01 frame writes its first, second and third data bytes to registers 1, 2 and 3 at chip-select release. Once that frame ends, the write-enable latch reads 0. Register contents never change in the middle of a frame.
- R4: Write masks are 0xFC for register 1, 0x7F for register 2 and 0x7F for register 3. Masked-off bits keep their value, and bit 7 of registers 2 and 3 always reads 0.
- R5: Opcode 0x50 arms a volatile enable that lets the next 0x01 frame write. It does not set register 1 bit 1, and it is consumed by that 0x01 frame.
- R6: A 0x01 frame that starts with neither the write-enable latch nor the volatile enable set changes no register.
- R7: If chip select rises partway through a data byte, that byte is discarded and the complete bytes before it still take effect.
- R8: Register 1 bit 0 mirrors the busy input one clock later. While busy is 1, opcodes 0x06, 0x04 and 0x50 are ignored, but status reads and 0x01 writes are still served.
- R9: Opcodes outside the command set are ignored, and MISO stays 0 whenever no read is in progress.
- R10: After reset all three registers and MISO are 0.
- R11: A 0x01 frame with fewer than three data bytes writes only the registers that received a complete byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| busy_in | input | 1 | Busy flag from array controller |
| sr1_o | output | 8 | Status register 1 view |
| sr2_o | output | 8 | Status register 2 view |
| sr3_o | output | 8 | Status register 3 view |

## Verification
The bench builds the unit with its default two-stage input synchronizer. It drives SCK with a half period of eight system clocks, which leaves four clocks of margin between a MISO change and the host sample. With three registers, a three-bit byte counter is elaborated. That lets one 0x01 frame reach every write slot and also lets the bench cut a frame off after one full byte plus a few bits. The busy input is toggled around enable and write frames, so the blocked and the still-served opcodes are both seen at the outputs.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam int REG_W  = 8;
  localparam int NUM_SR = 3;

  localparam logic [REG_W-1:0] OP_WRSR  = 8'h01;
  localparam logic [REG_W-1:0] OP_WRDI  = 8'h04;
  localparam logic [REG_W-1:0] OP_RDSR1 = 8'h05;
  localparam logic [REG_W-1:0] OP_WREN  = 8'h06;
  localparam logic [REG_W-1:0] OP_RDSR3 = 8'h33;
  localparam logic [REG_W-1:0] OP_RDSR2 = 8'h35;
  localparam logic [REG_W-1:0] OP_VWREN = 8'h50;

  // writable bits per register, index 0 = register 1
  localparam logic [NUM_SR-1:0][REG_W-1:0] WR_MASK = {8'h7F, 8'h7F, 8'hFC};

  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WREN,
    CMD_WRDI,
    CMD_VWREN,
    CMD_WRSR,
    CMD_SKIP
  } cmd_e;
endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sfsr_shifter.sv
module sfsr_shifter import sfsr_pkg::*; #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_s,
  input  logic             csn_s,
  input  logic             mosi_s,
  input  logic             tx_load,
  input  logic [REG_W-1:0] tx_data,
  output logic             frame_start,
  output logic             frame_end,
  output logic             in_frame,
  output logic             byte_valid,
  output logic [IDX_W-1:0] byte_idx,
  output logic [REG_W-1:0] rx_byte,
  output logic             miso
);
  localparam int               BIT_W    = $clog2(REG_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(REG_W - 1);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;

  logic             sck_d, csn_d;
  logic [BIT_W-1:0] bit_cnt;
  logic [IDX_W-1:0] byte_cnt;
  logic [REG_W-1:0] rx_sr, tx_sr;
  logic             sck_rise, sck_fall;

  assign frame_start = csn_d & ~csn_s;
  assign frame_end   = ~csn_d & csn_s;
  assign sck_rise    = in_frame & sck_s & ~sck_d;
  assign sck_fall    = in_frame & ~sck_s & sck_d;
  assign byte_valid  = sck_rise && (bit_cnt == LAST_BIT);
  assign rx_byte     = {rx_sr[REG_W-2:0], mosi_s};
  assign byte_idx    = byte_cnt;
  assign miso        = tx_sr[REG_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      csn_d    <= 1'b1;
      in_frame <= 1'b0;
    end else begin
      sck_d <= sck_s;
      csn_d <= csn_s;
      if (frame_start)    in_frame <= 1'b1;
      else if (frame_end) in_frame <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sr    <= '0;
    end else if (sck_rise) begin
      rx_sr   <= rx_byte;
      bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
      if (byte_valid && byte_cnt != IDX_MAX) byte_cnt <= byte_cnt + 1'b1;
    end
  end

  // output shifter: load at a byte boundary, shift on falls inside a byte
  always_ff @(posedge clk) begin
    if (rst || frame_start || frame_end) begin
      tx_sr <= '0;
    end else if (tx_load) begin
      tx_sr <= tx_data;
    end else if (sck_fall && bit_cnt != '0) begin
      tx_sr <= {tx_sr[REG_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sfsr_decode.sv
module sfsr_decode import sfsr_pkg::*; #(
  parameter int IDX_W = 3,
  parameter int SEL_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         frame_start,
  input  logic                         frame_end,
  input  logic                         byte_valid,
  input  logic [IDX_W-1:0]             byte_idx,
  input  logic [REG_W-1:0]             rx_byte,
  input  logic                         busy,
  input  logic                         wel,
  input  logic                         ven,
  output logic                         tx_load,
  output logic [SEL_W-1:0]             rd_sel,
  output logic                         do_wren,
  output logic                         do_wrdi,
  output logic                         do_vwren,
  output logic                         do_wrsr,
  output logic [IDX_W-1:0]             wr_cnt,
  output logic [NUM_SR-1:0][REG_W-1:0] wr_data
);
  cmd_e             cmd_q, op_cmd;
  logic [SEL_W-1:0] sel_q, op_sel;
  logic             first_byte;

  assign first_byte = (byte_idx == '0);

  always_comb begin
    op_cmd = CMD_SKIP;
    op_sel = '0;
    case (rx_byte)
      OP_RDSR1: begin op_cmd = CMD_READ; op_sel = SEL_W'(0); end
      OP_RDSR2: begin op_cmd = CMD_READ; op_sel = SEL_W'(1); end
      OP_RDSR3: begin op_cmd = CMD_READ; op_sel = SEL_W'(2); end
      OP_WRSR:  op_cmd = (wel || ven) ? CMD_WRSR : CMD_SKIP;
      OP_WREN:  op_cmd = busy ? CMD_SKIP : CMD_WREN;
      OP_WRDI:  op_cmd = busy ? CMD_SKIP : CMD_WRDI;
      OP_VWREN: op_cmd = busy ? CMD_SKIP : CMD_VWREN;
      default:  op_cmd = CMD_SKIP;
    endcase
  end

  assign rd_sel  = first_byte ? op_sel : sel_q;
  assign tx_load = byte_valid &&
                   ((first_byte && op_cmd == CMD_READ) ||
                    (!first_byte && cmd_q == CMD_READ));

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      cmd_q  <= CMD_NONE;
      sel_q  <= '0;
      wr_cnt <= '0;
    end else if (byte_valid) begin
      if (first_byte) begin
        cmd_q <= op_cmd;
        sel_q <= op_sel;
      end else if (cmd_q == CMD_WRSR && int'(byte_idx) <= NUM_SR) begin
        wr_cnt <= byte_idx;
      end
    end
  end

  // staging for the data bytes; no reset needed, gated by wr_cnt
  always_ff @(posedge clk) begin
    if (byte_valid && cmd_q == CMD_WRSR) begin
      for (int k = 0; k < NUM_SR; k++) begin
        if (int'(byte_idx) == k + 1) wr_data[k] <= rx_byte;
      end
    end
  end

  assign do_wren  = frame_end && cmd_q == CMD_WREN;
  assign do_wrdi  = frame_end && cmd_q == CMD_WRDI;
  assign do_vwren = frame_end && cmd_q == CMD_VWREN;
  assign do_wrsr  = frame_end && cmd_q == CMD_WRSR;
endmodule

// File: rtl/sfsr_regs.sv
module sfsr_regs import sfsr_pkg::*; #(
  parameter int IDX_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         busy_in,
  input  logic                         do_wren,
  input  logic                         do_wrdi,
  input  logic                         do_vwren,
  input  logic                         do_wrsr,
  input  logic [IDX_W-1:0]             wr_cnt,
  input  logic [NUM_SR-1:0][REG_W-1:0] wr_data,
  output logic [NUM_SR-1:0][REG_W-1:0] sr_view,
  output logic                         busy_q,
  output logic                         wel_q,
  output logic                         ven_q
);
  logic [NUM_SR-1:0][REG_W-1:0] cfg_q;

  genvar g;
  generate
    for (g = 0; g < NUM_SR; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          cfg_q[g] <= '0;
        end else if (do_wrsr && int'(wr_cnt) > g) begin
          cfg_q[g] <= (cfg_q[g] & ~WR_MASK[g]) | (wr_data[g] & WR_MASK[g]);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      ven_q  <= 1'b0;
    end else begin
      busy_q <= busy_in;
      if (do_wrsr || do_wrdi) wel_q <= 1'b0;
      else if (do_wren)       wel_q <= 1'b1;
      if (do_wrsr || do_wrdi) ven_q <= 1'b0;
      else if (do_vwren)      ven_q <= 1'b1;
    end
  end

  always_comb begin
    sr_view              = cfg_q;
    sr_view[0][WEL_BIT]  = wel_q;
    sr_view[0][BUSY_BIT] = busy_q;
  end
endmodule

// File: rtl/sfsr_unit.sv
module sfsr_unit import sfsr_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sck,
  input  logic             spi_csn,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             busy_in,
  output logic [REG_W-1:0] sr1_o,
  output logic [REG_W-1:0] sr2_o,
  output logic [REG_W-1:0] sr3_o
);
  localparam int IDX_W = $clog2(NUM_SR + 2);
  localparam int SEL_W = (NUM_SR > 1) ? $clog2(NUM_SR) : 1;

  logic [2:0]                   pins_s;
  logic                         frame_start, frame_end, in_frame, byte_valid;
  logic [IDX_W-1:0]             byte_idx, wr_cnt;
  logic [REG_W-1:0]             rx_byte;
  logic                         tx_load;
  logic [SEL_W-1:0]             rd_sel;
  logic                         do_wren, do_wrdi, do_vwren, do_wrsr;
  logic [NUM_SR-1:0][REG_W-1:0] wr_data, sr_view;
  logic                         busy_q, wel_q, ven_q;
  logic [REG_W-1:0]             rd_data;

  sfsr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sck, spi_csn, spi_mosi}),
    .q   (pins_s)
  );

  assign rd_data = (int'(rd_sel) < NUM_SR) ? sr_view[rd_sel] : '0;

  sfsr_shifter #(.IDX_W(IDX_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .sck_s       (pins_s[2]),
    .csn_s       (pins_s[1]),
    .mosi_s      (pins_s[0]),
    .tx_load     (tx_load),
    .tx_data     (rd_data),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .in_frame    (in_frame),
    .byte_valid  (byte_valid),
    .byte_idx    (byte_idx),
    .rx_byte     (rx_byte),
    .miso        (spi_miso)
  );

  sfsr_decode #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .byte_valid  (byte_valid),
    .byte_idx    (byte_idx),
    .rx_byte     (rx_byte),
    .busy        (busy_q),
    .wel         (wel_q),
    .ven         (ven_q),
    .tx_load     (tx_load),
    .rd_sel      (rd_sel),
    .do_wren     (do_wren),
    .do_wrdi     (do_wrdi),
    .do_vwren    (do_vwren),
    .do_wrsr     (do_wrsr),
    .wr_cnt      (wr_cnt),
    .wr_data     (wr_data)
  );

  sfsr_regs #(.IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .busy_in  (busy_in),
    .do_wren  (do_wren),
    .do_wrdi  (do_wrdi),
    .do_vwren (do_vwren),
    .do_wrsr  (do_wrsr),
    .wr_cnt   (wr_cnt),
    .wr_data  (wr_data),
    .sr_view  (sr_view),
    .busy_q   (busy_q),
    .wel_q    (wel_q),
    .ven_q    (ven_q)
  );

  assign sr1_o = sr_view[0];
  assign sr2_o = sr_view[1];
  assign sr3_o = sr_view[2];
endmodule

// File: rtl/sfsr_unit_chk.sv
module sfsr_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy_in,
  input logic       spi_miso,
  input logic [7:0] sr1_o,
  input logic [7:0] sr2_o,
  input logic [7:0] sr3_o,
  input logic       in_frame,
  input logic       frame_end,
  input logic       do_wren,
  input logic       do_wrsr
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sr2_o[7] == 1'b0 && sr3_o[7] == 1'b0)); // R4

  AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sr1_o[0] == $past(busy_in))); // R8

  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(sr2_o) && $stable(sr3_o) && $stable(sr1_o[7:1]))); // R3

  AST_WEL_DROP: assert property (@(posedge clk) disable iff (rst)
    (frame_end && do_wrsr) |=> !sr1_o[1]); // R3

  AST_WEL_RISE: assert property (@(posedge clk) disable iff (rst)
    (frame_end && do_wren) |=> sr1_o[1]); // R2

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_frame |-> !spi_miso); // R9
endmodule

bind sfsr_unit sfsr_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy_in   (busy_in),
  .spi_miso  (spi_miso),
  .sr1_o     (sr1_o),
  .sr2_o     (sr2_o),
  .sr3_o     (sr3_o),
  .in_frame  (in_frame),
  .frame_end (frame_end),
  .do_wren   (do_wren),
  .do_wrsr   (do_wrsr)
);

// File: tb/sfsr_unit_test.sv
module sfsr_unit_test;
  localparam int HALF = 8;
  localparam int WDOG = 150000;

  logic       clk = 1'b0;
  logic       rst, spi_sck, spi_csn, spi_mosi, busy_in;
  logic       spi_miso;
  logic [7:0] sr1_o, sr2_o, sr3_o;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sfsr_unit uut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .busy_in(busy_in),
    .sr1_o(sr1_o), .sr2_o(sr2_o), .sr3_o(sr3_o)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input int nbytes, input int extra_bits);
    spi_csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbytes; i++) begin
      for (int b = 7; b >= 0; b--) begin
        spi_mosi = txb[i][b];
        wait_clk(HALF);
        rxb[i][b] = spi_miso;
        spi_sck = 1'b1;
        wait_clk(HALF);
        spi_sck = 1'b0;
      end
    end
    for (int j = 0; j < extra_bits; j++) begin
      spi_mosi = txb[nbytes][7-j];
      wait_clk(HALF);
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
    wait_clk(HALF);
    spi_csn = 1'b1;
    spi_mosi = 1'b0;
    wait_clk(4*HALF);
  endtask

  task automatic op(input logic [7:0] code);
    txb[0] = code;
    run_frame(1, 0);
  endtask

  task automatic wrsr(input int n, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    txb[0] = 8'h01; txb[1] = a; txb[2] = b; txb[3] = c;
    run_frame(n + 1, 0);
  endtask

  task automatic rdsr(input logic [7:0] code, input int n);
    txb[0] = code;
    for (int i = 1; i < 8; i++) txb[i] = 8'h00;
    run_frame(n + 1, 0);
  endtask

  task automatic t_reset;
    chk("R10 sr1", sr1_o, 8'h00);
    chk("R10 sr2", sr2_o, 8'h00);
    chk("R10 sr3", sr3_o, 8'h00);
    chk("R10 miso", {7'd0, spi_miso}, 8'h00);
  endtask

  task automatic t_wel;
    op(8'h06);
    chk("R2 wel set", sr1_o, 8'h02);
    rdsr(8'h05, 1);
    chk("R1 read sr1", rxb[1], 8'h02);
    op(8'h04);
    chk("R2 wel clear", sr1_o, 8'h00);
  endtask

  task automatic t_write_all;
    op(8'h06);
    wrsr(3, 8'hFF, 8'hFF, 8'hFF);
    chk("R4 sr1 mask", sr1_o, 8'hFC);
    chk("R4 sr2 mask", sr2_o, 8'h7F);
    chk("R4 sr3 mask", sr3_o, 8'h7F);
    rdsr(8'h35, 2);
    chk("R1 read sr2", rxb[1], 8'h7F);
    chk("R1 repeat sr2", rxb[2], 8'h7F);
    rdsr(8'h33, 1);
    chk("R1 read sr3", rxb[1], 8'h7F);
  endtask

  task automatic t_write_order;
    op(8'h06);
    wrsr(3, 8'hA4, 8'h5A, 8'h3C);
    chk("R3 sr1", sr1_o, 8'hA4);
    chk("R3 sr2", sr2_o, 8'h5A);
    chk("R3 sr3", sr3_o, 8'h3C);
  endtask

  task automatic t_write_short;
    op(8'h06);
    wrsr(1, 8'h08, 8'h00, 8'h00);
    chk("R11 sr1", sr1_o, 8'h08);
    chk("R11 sr2 kept", sr2_o, 8'h5A);
    chk("R11 sr3 kept", sr3_o, 8'h3C);
  endtask

  task automatic t_no_enable;
    wrsr(3, 8'h00, 8'h00, 8'h00);
    chk("R6 sr1", sr1_o, 8'h08);
    chk("R6 sr2", sr2_o, 8'h5A);
    chk("R6 sr3", sr3_o, 8'h3C);
  endtask

  task automatic t_partial;
    op(8'h06);
    txb[0] = 8'h01; txb[1] = 8'hC0; txb[2] = 8'hFF;
    run_frame(2, 3);
    chk("R7 sr1 whole byte", sr1_o, 8'hC0);
    chk("R7 sr2 partial dropped", sr2_o, 8'h5A);
  endtask

  task automatic t_volatile;
    op(8'h50);
    chk("R5 wel untouched", sr1_o, 8'hC0);
    wrsr(3, 8'h10, 8'h11, 8'h12);
    chk("R5 sr1", sr1_o, 8'h10);
    chk("R5 sr2", sr2_o, 8'h11);
    chk("R5 sr3", sr3_o, 8'h12);
    wrsr(3, 8'h00, 8'h00, 8'h00);
    chk("R5 consumed", sr2_o, 8'h11);
    op(8'h50);
    op(8'h04);
    wrsr(1, 8'hFC, 8'h00, 8'h00);
    chk("R2 wrdi cancels volatile", sr1_o, 8'h10);
  endtask

  task automatic t_busy;
    busy_in = 1'b1;
    wait_clk(4);
    chk("R8 busy bit", sr1_o, 8'h11);
    op(8'h06);
    chk("R8 wren blocked", sr1_o, 8'h11);
    rdsr(8'h05, 1);
    chk("R8 read while busy", rxb[1], 8'h11);
    busy_in = 1'b0;
    wait_clk(4);
    op(8'h06);
    chk("R2 wel before busy", sr1_o, 8'h12);
    busy_in = 1'b1;
    wait_clk(4);
    op(8'h04);
    chk("R8 wrdi blocked", sr1_o, 8'h13);
    wrsr(1, 8'h20, 8'h00, 8'h00);
    chk("R8 write while busy", sr1_o, 8'h21);
    busy_in = 1'b0;
    wait_clk(4);
    chk("R8 busy released", sr1_o, 8'h20);
  endtask

  task automatic t_unknown;
    rdsr(8'h9F, 2);
    chk("R9 byte1", rxb[1], 8'h00);
    chk("R9 byte2", rxb[2], 8'h00);
    chk("R9 regs kept", sr1_o, 8'h20);
    chk("R9 miso idle", {7'd0, spi_miso}, 8'h00);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; spi_sck = 1'b0; spi_csn = 1'b1; spi_mosi = 1'b0; busy_in = 1'b0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset;
    t_wel;
    t_write_all;
    t_write_order;
    t_write_short;
    t_no_enable;
    t_partial;
    t_volatile;
    t_busy;
    t_unknown;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule